// File: doc/BRIEF.md
# Timed Moore Pacing Controller

This block watches a one-bit rhythm indication and produces a one-bit pacing pulse. When the indication stays high, an external rhythm is present and the output stays low. When the indication stays low, the block emits a pulse exactly 10 ms wide that starts once every second. It is a Moore machine, so the output depends only on the current state. Each state has its own fixed dwell time. The input is examined only once, at the moment that dwell runs out, and that single sample chooses the next state.

The dwell time is measured by a prescaler and a millisecond counter. The prescaler turns the system clock into one tick per millisecond, and the millisecond counter counts those ticks. Both counters are cleared each time a state is entered, including when a state loops back to itself, so every dwell is an exact multiple of the clock period. The raw input is asynchronous and passes through a two-flop synchronizer before the state logic uses it.

A parameter selects one of two forms:
- The three-state form goes watch (10 ms), then wait (980 ms), then pace (10 ms).
- The two-state form goes check (990 ms), then pace (10 ms).

Under a constantly low input, both forms give the same pulse timing.

Top module: `pace_ctrl`

## Requirements
- R1: Reset is active low and asynchronous. It drives `pace_out` low, places the machine in its home state (watch, or check in the two-state form) and clears both timer counters. With `beat_in` held low from reset, the first pulse rises at clock edge 990*CYC_PER_MS after reset is released, counting the first edge after release as edge 1.
- R2: `pace_out` is high only in the pace state. It remains low for as long as `beat_in` is held high.
- R3: The watch state dwells 10 ms. When it expires, a low input selects wait and a high input keeps the machine in watch.
- R4: The wait state dwells 980 ms. When it expires, a low input selects pace and a high input selects watch.
- R5: The pace state dwells 10 ms. It then returns to the home state whatever the input value, including when the input rises during the pulse.
- R6: While `beat_in` stays low, each pulse is exactly 10*CYC_PER_MS cycles wide, and successive rising edges are 1000*CYC_PER_MS cycles apart.
- R7: The input is used only at a dwell expiry, through a two-flop synchronizer. A change driven just after clock edge n affects decisions at expiry edges n+3 and later.
- R8: The dwell timer restarts on every state entry, self-loops included. In the three-state form with a high input, watch expiries therefore fall every 10*CYC_PER_MS edges from reset.
- R9: With TWO_STATE=1, the check state dwells 990 ms. When it expires, a low input selects pace and a high input keeps check. Pace dwells 10 ms and then returns to check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_in | input | 1 | Asynchronous rhythm indication; high means a rhythm is present |
| pace_out | output | 1 | Pacing pulse; high only in the pace state |

## Verification
A wrong state or a corrupted dwell counter has one visible effect: the pulse edges move. A pulse may rise early or late, a pulse may be missing, or a pulse may be stretched. Because every dwell is an exact cycle count, the bench predicts the edge number of every rising and falling edge and compares `pace_out` on every cycle. An error therefore shows up on the first cycle where the timing differs, at the latest one dwell period (about 1000 ms of ticks) after the fault. The bench sweeps the cycle at which the input drops across a full watch period, which exposes off-by-one errors in the synchronizer latency and in the timer reload.

// File: rtl/pace_pkg.sv
package pace_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PACE  = 2'd2
    } pace_state_e;

    typedef struct packed {
        pace_state_e state;
        logic        pace;
    } pace_reg_t;

endpackage

// File: rtl/pace_sync.sv
module pace_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic synced
);

    typedef struct packed {
        logic meta;
        logic sync;
    } sync_reg_t;

    sync_reg_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = raw;
        sync_d.sync = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{meta: RST_VAL, sync: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign synced = sync_q.sync;

endmodule

// File: rtl/pace_dwell_timer.sv
module pace_dwell_timer #(
    parameter int CYC_PER_MS = 100000,
    parameter int MS_W       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MS_W-1:0] dwell_ms,
    output logic            done
);

    localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [MS_W-1:0]  ms;
    } tmr_reg_t;

    tmr_reg_t tmr_d, tmr_q;
    logic     tick;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.pre == PRE_LAST);
        done  = tick && (tmr_q.ms == (dwell_ms - MS_W'(1)));
        if (tick) begin
            tmr_d.pre = '0;
            tmr_d.ms  = done ? '0 : tmr_q.ms + MS_W'(1);
        end else begin
            tmr_d.pre = tmr_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R8
    prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.pre <= PRE_LAST);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tmr_q.pre == '0 && tmr_q.ms == '0));

endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl
    import pace_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int MON_MS     = 10,
    parameter int WAIT_MS    = 980,
    parameter int PACE_MS    = 10,
    parameter int CHECK_MS   = 990,
    parameter bit TWO_STATE  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_in,
    output logic pace_out
);

    localparam int MAX_A  = (MON_MS > WAIT_MS) ? MON_MS : WAIT_MS;
    localparam int MAX_B  = (PACE_MS > CHECK_MS) ? PACE_MS : CHECK_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MS_W   = $clog2(MAX_MS + 1);

    logic            beat_s;
    logic            done;
    logic [MS_W-1:0] dwell_ms;
    logic [MS_W-1:0] home_ms;
    pace_state_e     home_low_next;
    pace_reg_t       fsm_d, fsm_q;

    pace_sync #(.RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (beat_in),
        .synced (beat_s)
    );

    pace_dwell_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .dwell_ms (dwell_ms),
        .done     (done)
    );

    generate
        if (TWO_STATE) begin : g_two
            assign home_ms       = MS_W'(CHECK_MS);
            assign home_low_next = ST_PACE;
        end else begin : g_three
            assign home_ms       = MS_W'(MON_MS);
            assign home_low_next = ST_WAIT;
        end
    endgenerate

    always_comb begin
        unique case (fsm_q.state)
            ST_WAIT: dwell_ms = MS_W'(WAIT_MS);
            ST_PACE: dwell_ms = MS_W'(PACE_MS);
            default: dwell_ms = home_ms;
        endcase
    end

    always_comb begin
        fsm_d = fsm_q;
        if (done) begin
            unique case (fsm_q.state)
                ST_WATCH: fsm_d.state = beat_s ? ST_WATCH : home_low_next;
                ST_WAIT:  fsm_d.state = beat_s ? ST_WATCH : ST_PACE;
                default:  fsm_d.state = ST_WATCH;
            endcase
        end
        fsm_d.pace = (fsm_d.state == ST_PACE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_WATCH, pace: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign pace_out = fsm_q.pace;

    // Checker-only pulse length counter
    localparam int PULSE_CYC = PACE_MS * CYC_PER_MS;
    localparam int HI_W      = $clog2(PULSE_CYC + 2);
    logic [HI_W-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (pace_out) begin
            hi_cnt_q <= hi_cnt_q + HI_W'(1);
        end else begin
            hi_cnt_q <= '0;
        end
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q <= HI_W'(PULSE_CYC));

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_out && hi_cnt_q == HI_W'(PULSE_CYC - 1)) |=> !pace_out);

    // R5
    pace_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_PACE && done) |=> fsm_q.state == ST_WATCH);

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(fsm_q.state));

    // R4
    wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT && done && beat_s) |=> fsm_q.state == ST_WATCH);

    // R3
    watch_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WATCH && done && beat_s) |=> fsm_q.state == ST_WATCH);

endmodule

// File: tb/pace_ctrl_bench.sv
`timescale 1ns/1ps
module pace_ctrl_bench;

    localparam int C = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic beat = 1'b1;
    logic out_a, out_b;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    pace_ctrl #(.CYC_PER_MS(C), .TWO_STATE(1'b0)) u_pace_ctrl (
        .clk(clk), .rst_n(rst_n), .beat_in(beat), .pace_out(out_a)
    );

    pace_ctrl #(.CYC_PER_MS(C), .TWO_STATE(1'b1)) u_pace_ctrl_two (
        .clk(clk), .rst_n(rst_n), .beat_in(beat), .pace_out(out_b)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, cyc, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic b);
        rst_n = 1'b0;
        beat  = b;
        repeat (3) @(posedge clk);
        #1;
        check(out_a, 1'b0, "R1", "three-state output in reset");
        check(out_b, 1'b0, "R1", "two-state output in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Low input from reset: periodic pulses in both forms
        do_reset(1'b0);
        while (cyc < 2990 * C) begin
            step();
            check(out_a, (cyc % (1000 * C)) >= 990 * C, (cyc <= 1000 * C) ? "R1" : "R6", "three-state periodic pulse");
            check(out_b, (cyc % (1000 * C)) >= 990 * C, "R9", "two-state periodic pulse");
        end
        // Input rises during the pulse: pulse still completes, then stays low
        beat = 1'b1;
        while (cyc < 6007 * C / 1 - 0 && cyc < 12007) begin
            step();
            check(out_a, cyc < 3000 * C, (cyc <= 3000 * C) ? "R5" : "R2", "three-state pulse end then quiet");
            check(out_b, cyc < 3000 * C, (cyc <= 3000 * C) ? "R5" : "R2", "two-state pulse end then quiet");
        end
        // Input drops at edge 12007; rises again at edge 14500 during wait
        beat = 1'b0;
        while (cyc < 16200) begin
            step();
            if (cyc == 14500) beat = 1'b1;
            check(out_a, (cyc >= 13980 && cyc < 14000), (cyc > 15900) ? "R4" : "R7", "three-state drop response");
            check(out_b, (cyc >= 13920 && cyc < 13940), (cyc > 15900) ? "R9" : "R7", "two-state drop response");
        end
        // Sweep the drop phase across a full watch period
        for (int d = 0; d < 24; d++) begin
            int n, ea, ra, rb;
            do_reset(1'b1);
            n  = 100 + d;
            ea = ((n + 3 + 10 * C - 1) / (10 * C)) * (10 * C);
            ra = ea + 980 * C;
            rb = ((n + 3 + 990 * C - 1) / (990 * C)) * (990 * C);
            while (cyc < n) begin
                step();
                check(out_a, 1'b0, "R3", "three-state quiet while high");
                check(out_b, 1'b0, "R9", "two-state quiet while high");
            end
            beat = 1'b0;
            while (cyc < ra + 40) begin
                step();
                check(out_a, (cyc >= ra && cyc < ra + 10 * C), "R8", "three-state phase sweep");
                check(out_b, (cyc >= rb && cyc < rb + 10 * C), "R7", "two-state phase sweep");
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule